// File: doc/BRIEF.md
# Four-Channel DMA Register Front-End

This block is the host-visible register file of a four-channel DMA controller. A byte-wide I/O bus reaches it through an 8-bit port number. Ports 0x00 to 0x0F form the controller's own register window, and four further ports hold a page byte for each channel. Each channel keeps a 16-bit address and a 16-bit count, in a base copy and a current copy, together with a mode byte and a mask bit. One shared byte pointer chooses whether an 8-bit access reaches the low or the high half of a 16-bit register.

A transfer engine reads the settings and masks of each channel from the outputs. It pulses one step input for each byte it moves. On each step of an unmasked channel, the current address counts up and the current count counts down. When the count passes through zero, that channel's terminal-count flag is raised. The 24-bit address seen by the engine is the page byte placed above the 16-bit current address. A step never carries into the page, so a transfer stays inside one 64 KiB block. The programmed count is one less than the number of bytes to move.

Top module: `dmaregs_front`

## Requirements
- R1: After reset all four masks are set (ch_mask = 4'hF), and the byte pointer, command, request, terminal-count flags, addresses, counts, modes and pages are all zero.
- R2: For channel n, port 2n reaches the address register and port 2n+1 reaches the count register. A write loads the chosen byte into both the base and the current copy. A read returns the chosen byte of the current copy. The byte pointer picks the byte: 0 selects the low byte, 1 selects the high byte.
- R3: Every read or write of ports 0x00 to 0x07 toggles the byte pointer. A write to port 0x0C clears the pointer, whatever the data.
- R4: A write to port 0x0A changes one mask only: data bits 1:0 name the channel, and data bit 2 is the new mask value (1 masks, 0 unmasks).
- R5: A write to port 0x0E clears all four masks. A write to port 0x0F sets all four masks.
- R6: A write to port 0x0B stores the whole data byte as the mode of the channel named by data bits 1:0. In that byte, bits 3:2 give the transfer type (01 read, 10 write) and bits 7:6 give the mode (01 single, 11 cascade).
- R7: The page bytes of channels 0, 1, 2 and 3 are written and read at ports 0x87, 0x83, 0x81 and 0x82. Each channel's address output is {page, current address}.
- R8: A step pulse on an unmasked channel adds one to its current address and takes one from its current count. The 16-bit address wraps from 0xFFFF to 0x0000 and leaves the page unchanged. A step on a masked channel has no effect. A step in the same cycle as a write to that channel's address or count port is also ignored.
- R9: A step taken when the current count is 0 sets the count to 0xFFFF and sets that channel's terminal-count flag. A read of port 0x08 returns {request[3:0], terminal-count[3:0]} and clears the flags; a flag raised in the same cycle as the read is kept.
- R10: A write to port 0x0D sets all masks and clears the command, the requests, the terminal-count flags and the byte pointer. It leaves the channel addresses, counts, modes and pages unchanged. A read of port 0x0D returns 0x00.
- R11: A write to port 0x08 stores the command byte. A write to port 0x09 sets the request bit of the channel named by data bits 1:0 to data bit 2.
- R12: A read of any port outside 0x00 to 0x08, 0x0D and the four page ports returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 8 | I/O port number |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access (ignored when io_wr is high) |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for io_addr, combinational |
| xfer_step | input | 4 | Per-channel step pulse from the transfer engine |
| ch_addr | output | 96 | Per-channel 24-bit address {page, current address} |
| ch_count | output | 64 | Per-channel current count |
| ch_base_addr | output | 64 | Per-channel base address |
| ch_base_count | output | 64 | Per-channel base count |
| ch_mode | output | 32 | Per-channel mode byte |
| ch_mask | output | 4 | Per-channel mask, 1 = masked |
| tc_flags | output | 4 | Per-channel terminal-count flags |
| sw_req | output | 4 | Per-channel software request bits |
| cmd_out | output | 8 | Command byte |

## Verification
Channel 0 is loaded byte by byte and then read back, which shows whether the byte pointer alternates the halves or sticks on one of them. Step pulses are applied in four situations: on an unmasked channel, on a masked channel, on a channel whose address sits at 0xFFFF, and in the same cycle as a write to the count port. Together these separate a plain count-down, mask gating, wrap without a carry into the page, and a write taking priority over a step. A master clear issued while the byte pointer is set, and a pointer clear written with all-ones data, show that each resets the pointer without touching the stored addresses. A behavioural model is compared with every output on every clock.

// File: rtl/dmaf_pkg.sv
package dmaf_pkg;
    localparam int NUM_CH  = 4;
    localparam int CH_W    = $clog2(NUM_CH);
    localparam int BYTE_W  = 8;
    localparam int WORD_W  = 2 * BYTE_W;
    localparam int PAGE_W  = 8;
    localparam int ADDR_W  = PAGE_W + WORD_W;
    localparam int PORT_W  = 8;
    localparam int OFS_W   = 4;
    localparam int VAL_BIT = 2;

    localparam logic [OFS_W-1:0] OFS_CMD     = 4'h8;
    localparam logic [OFS_W-1:0] OFS_REQ     = 4'h9;
    localparam logic [OFS_W-1:0] OFS_MASK1   = 4'hA;
    localparam logic [OFS_W-1:0] OFS_MODE    = 4'hB;
    localparam logic [OFS_W-1:0] OFS_CLRPTR  = 4'hC;
    localparam logic [OFS_W-1:0] OFS_MCLR    = 4'hD;
    localparam logic [OFS_W-1:0] OFS_UNMASK  = 4'hE;
    localparam logic [OFS_W-1:0] OFS_MASKALL = 4'hF;

    function automatic logic [PORT_W-1:0] page_port(input int ch);
        case (ch)
            0:       return 8'h87;
            1:       return 8'h83;
            2:       return 8'h81;
            default: return 8'h82;
        endcase
    endfunction

    typedef struct packed {
        logic              cmd_wr;
        logic              req_wr;
        logic              mask1_wr;
        logic              mode_wr;
        logic              clrptr_wr;
        logic              mclr_wr;
        logic              unmask_wr;
        logic              maskall_wr;
        logic              stat_rd;
        logic              chan_acc;
        logic [NUM_CH-1:0] addr_wr;
        logic [NUM_CH-1:0] cnt_wr;
        logic [NUM_CH-1:0] page_wr;
    } dec_t;
endpackage

// File: rtl/dmaf_decode.sv
module dmaf_decode
    import dmaf_pkg::*;
(
    input  logic [PORT_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    output dec_t              dec,
    output logic [NUM_CH-1:0] page_hit,
    output logic              reg_hit
);
    logic [OFS_W-1:0] ofs;
    logic             rd_e;
    logic             chan_port;

    assign ofs       = io_addr[OFS_W-1:0];
    assign reg_hit   = (io_addr[PORT_W-1:OFS_W] == '0);
    assign rd_e      = io_rd && !io_wr;
    assign chan_port = reg_hit && !ofs[OFS_W-1];

    assign dec.cmd_wr     = io_wr && reg_hit && (ofs == OFS_CMD);
    assign dec.req_wr     = io_wr && reg_hit && (ofs == OFS_REQ);
    assign dec.mask1_wr   = io_wr && reg_hit && (ofs == OFS_MASK1);
    assign dec.mode_wr    = io_wr && reg_hit && (ofs == OFS_MODE);
    assign dec.clrptr_wr  = io_wr && reg_hit && (ofs == OFS_CLRPTR);
    assign dec.mclr_wr    = io_wr && reg_hit && (ofs == OFS_MCLR);
    assign dec.unmask_wr  = io_wr && reg_hit && (ofs == OFS_UNMASK);
    assign dec.maskall_wr = io_wr && reg_hit && (ofs == OFS_MASKALL);
    assign dec.stat_rd    = rd_e && reg_hit && (ofs == OFS_CMD);
    assign dec.chan_acc   = (io_wr || rd_e) && chan_port;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
        assign dec.addr_wr[g] = io_wr && chan_port && (ofs[CH_W:1] == CH_W'(g)) && !ofs[0];
        assign dec.cnt_wr[g]  = io_wr && chan_port && (ofs[CH_W:1] == CH_W'(g)) && ofs[0];
        assign page_hit[g]    = (io_addr == page_port(g));
        assign dec.page_wr[g] = io_wr && page_hit[g];
    end
endmodule

// File: rtl/dmaf_chan.sv
module dmaf_chan
    import dmaf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_wr,
    input  logic              cnt_wr,
    input  logic              page_wr,
    input  logic              mode_wr,
    input  logic              hi_sel,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              step_en,
    output logic [WORD_W-1:0] cur_addr,
    output logic [WORD_W-1:0] cur_cnt,
    output logic [WORD_W-1:0] base_addr,
    output logic [WORD_W-1:0] base_cnt,
    output logic [BYTE_W-1:0] mode,
    output logic [PAGE_W-1:0] page,
    output logic              tc_pulse
);
    typedef struct packed {
        logic [WORD_W-1:0] cur_addr;
        logic [WORD_W-1:0] base_addr;
        logic [WORD_W-1:0] cur_cnt;
        logic [WORD_W-1:0] base_cnt;
        logic [BYTE_W-1:0] mode;
        logic [PAGE_W-1:0] page;
    } chan_t;

    chan_t chan_q, chan_d;
    logic  step_go;

    function automatic logic [WORD_W-1:0] put_byte(input logic [WORD_W-1:0] w,
                                                   input logic hi,
                                                   input logic [BYTE_W-1:0] b);
        logic [WORD_W-1:0] r;
        r = w;
        if (hi) r[WORD_W-1:BYTE_W] = b;
        else    r[BYTE_W-1:0]      = b;
        return r;
    endfunction

    always_comb begin
        chan_d   = chan_q;
        step_go  = step_en && !addr_wr && !cnt_wr;
        tc_pulse = step_go && (chan_q.cur_cnt == '0);
        if (step_go) begin
            chan_d.cur_addr = chan_q.cur_addr + WORD_W'(1);
            chan_d.cur_cnt  = chan_q.cur_cnt - WORD_W'(1);
        end
        if (addr_wr) begin
            chan_d.cur_addr  = put_byte(chan_q.cur_addr, hi_sel, wdata);
            chan_d.base_addr = put_byte(chan_q.base_addr, hi_sel, wdata);
        end
        if (cnt_wr) begin
            chan_d.cur_cnt  = put_byte(chan_q.cur_cnt, hi_sel, wdata);
            chan_d.base_cnt = put_byte(chan_q.base_cnt, hi_sel, wdata);
        end
        if (mode_wr) chan_d.mode = wdata;
        if (page_wr) chan_d.page = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chan_q <= '0;
        else        chan_q <= chan_d;
    end

    assign cur_addr  = chan_q.cur_addr;
    assign cur_cnt   = chan_q.cur_cnt;
    assign base_addr = chan_q.base_addr;
    assign base_cnt  = chan_q.base_cnt;
    assign mode      = chan_q.mode;
    assign page      = chan_q.page;

    a_r8_step_counts: assert property (@(posedge clk) disable iff (!rst_n)
        step_en && !addr_wr && !cnt_wr |=>
            (cur_addr == $past(cur_addr) + WORD_W'(1)) && (cur_cnt == $past(cur_cnt) - WORD_W'(1)));

    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en && !addr_wr && !cnt_wr |=> $stable(cur_addr) && $stable(cur_cnt));

    a_r9_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
        step_en && !addr_wr && !cnt_wr && (cur_cnt == '0) |-> tc_pulse);

    a_r7_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !page_wr |=> $stable(page));
endmodule

// File: rtl/dmaregs_front.sv
module dmaregs_front
    import dmaf_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [PORT_W-1:0]        io_addr,
    input  logic                     io_wr,
    input  logic                     io_rd,
    input  logic [BYTE_W-1:0]        io_wdata,
    output logic [BYTE_W-1:0]        io_rdata,
    input  logic [NUM_CH-1:0]        xfer_step,
    output logic [NUM_CH*ADDR_W-1:0] ch_addr,
    output logic [NUM_CH*WORD_W-1:0] ch_count,
    output logic [NUM_CH*WORD_W-1:0] ch_base_addr,
    output logic [NUM_CH*WORD_W-1:0] ch_base_count,
    output logic [NUM_CH*BYTE_W-1:0] ch_mode,
    output logic [NUM_CH-1:0]        ch_mask,
    output logic [NUM_CH-1:0]        tc_flags,
    output logic [NUM_CH-1:0]        sw_req,
    output logic [BYTE_W-1:0]        cmd_out
);
    typedef struct packed {
        logic [NUM_CH-1:0] mask;
        logic [NUM_CH-1:0] tc;
        logic [NUM_CH-1:0] req;
        logic [BYTE_W-1:0] cmd;
        logic              ptr;
    } ctl_t;

    ctl_t              ctl_q, ctl_d;
    dec_t              dec;
    logic [NUM_CH-1:0] page_hit;
    logic              reg_hit;
    logic [OFS_W-1:0]  ofs;
    logic [NUM_CH-1:0] tc_pulse;
    logic [CH_W-1:0]   wsel;
    logic [CH_W-1:0]   rsel;
    logic [WORD_W-1:0] rword;
    logic [WORD_W-1:0] cur_addr_w [NUM_CH];
    logic [WORD_W-1:0] cur_cnt_w  [NUM_CH];
    logic [PAGE_W-1:0] page_w     [NUM_CH];

    assign ofs  = io_addr[OFS_W-1:0];
    assign wsel = io_wdata[CH_W-1:0];
    assign rsel = ofs[CH_W:1];

    dmaf_decode u_dec (
        .io_addr  (io_addr),
        .io_wr    (io_wr),
        .io_rd    (io_rd),
        .dec      (dec),
        .page_hit (page_hit),
        .reg_hit  (reg_hit)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        dmaf_chan u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .addr_wr   (dec.addr_wr[g]),
            .cnt_wr    (dec.cnt_wr[g]),
            .page_wr   (dec.page_wr[g]),
            .mode_wr   (dec.mode_wr && (wsel == CH_W'(g))),
            .hi_sel    (ctl_q.ptr),
            .wdata     (io_wdata),
            .step_en   (xfer_step[g] && !ctl_q.mask[g]),
            .cur_addr  (cur_addr_w[g]),
            .cur_cnt   (cur_cnt_w[g]),
            .base_addr (ch_base_addr[g*WORD_W +: WORD_W]),
            .base_cnt  (ch_base_count[g*WORD_W +: WORD_W]),
            .mode      (ch_mode[g*BYTE_W +: BYTE_W]),
            .page      (page_w[g]),
            .tc_pulse  (tc_pulse[g])
        );
        assign ch_addr[g*ADDR_W +: ADDR_W]  = {page_w[g], cur_addr_w[g]};
        assign ch_count[g*WORD_W +: WORD_W] = cur_cnt_w[g];
    end

    always_comb begin
        ctl_d = ctl_q;
        if (dec.chan_acc)   ctl_d.ptr = ~ctl_q.ptr;
        if (dec.clrptr_wr)  ctl_d.ptr = 1'b0;
        if (dec.cmd_wr)     ctl_d.cmd = io_wdata;
        if (dec.req_wr)     ctl_d.req[wsel] = io_wdata[VAL_BIT];
        if (dec.mask1_wr)   ctl_d.mask[wsel] = io_wdata[VAL_BIT];
        if (dec.unmask_wr)  ctl_d.mask = '0;
        if (dec.maskall_wr) ctl_d.mask = '1;
        if (dec.stat_rd)    ctl_d.tc = '0;
        ctl_d.tc = ctl_d.tc | tc_pulse;
        if (dec.mclr_wr) begin
            ctl_d.mask = '1;
            ctl_d.cmd  = '0;
            ctl_d.req  = '0;
            ctl_d.tc   = '0;
            ctl_d.ptr  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            ctl_q.mask <= '1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        io_rdata = '0;
        rword    = ofs[0] ? cur_cnt_w[rsel] : cur_addr_w[rsel];
        if (reg_hit) begin
            if (!ofs[OFS_W-1])
                io_rdata = ctl_q.ptr ? rword[WORD_W-1:BYTE_W] : rword[BYTE_W-1:0];
            else if (ofs == OFS_CMD)
                io_rdata = BYTE_W'({ctl_q.req, ctl_q.tc});
        end else begin
            for (int c = 0; c < NUM_CH; c++)
                if (page_hit[c]) io_rdata = page_w[c];
        end
    end

    assign ch_mask  = ctl_q.mask;
    assign tc_flags = ctl_q.tc;
    assign sw_req   = ctl_q.req;
    assign cmd_out  = ctl_q.cmd;

    a_r10_master_clear: assert property (@(posedge clk) disable iff (!rst_n)
        dec.mclr_wr |=> (ch_mask == '1) && (tc_flags == '0) && (sw_req == '0) && (cmd_out == '0));

    a_r3_ptr_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        dec.chan_acc |=> ctl_q.ptr != $past(ctl_q.ptr));

    a_r3_ptr_clear: assert property (@(posedge clk) disable iff (!rst_n)
        dec.clrptr_wr |=> !ctl_q.ptr);

    a_r9_status_clear: assert property (@(posedge clk) disable iff (!rst_n)
        dec.stat_rd && (tc_pulse == '0) |=> tc_flags == '0);

    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !dec.stat_rd && !dec.mclr_wr |=> (tc_flags & $past(tc_flags)) == $past(tc_flags));

    a_r5_mask_all: assert property (@(posedge clk) disable iff (!rst_n)
        dec.maskall_wr |=> ch_mask == '1);

    a_r5_unmask_all: assert property (@(posedge clk) disable iff (!rst_n)
        dec.unmask_wr |=> ch_mask == '0);

    a_r4_single_mask: assert property (@(posedge clk) disable iff (!rst_n)
        dec.mask1_wr |=> $countones(ch_mask ^ $past(ch_mask)) <= 1);
endmodule

// File: tb/dmaregs_front_tb.sv
module dmaregs_front_tb;
    import dmaf_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic              io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0]        io_addr = '0, io_wdata = '0;
    logic [3:0]        xfer_step = '0;
    logic [7:0]        io_rdata;
    logic [95:0]       ch_addr;
    logic [63:0]       ch_count, ch_base_addr, ch_base_count;
    logic [31:0]       ch_mode;
    logic [3:0]        ch_mask, tc_flags, sw_req;
    logic [7:0]        cmd_out;

    dmaregs_front u_dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .xfer_step(xfer_step),
        .ch_addr(ch_addr), .ch_count(ch_count), .ch_base_addr(ch_base_addr),
        .ch_base_count(ch_base_count), .ch_mode(ch_mode), .ch_mask(ch_mask),
        .tc_flags(tc_flags), .sw_req(sw_req), .cmd_out(cmd_out)
    );

    int checks = 0, fails = 0;
    bit done = 0;
    logic [7:0] last_rd;

    // behavioural reference state
    logic [15:0] m_ca[4], m_ba[4], m_cc[4], m_bc[4];
    logic [7:0]  m_mode[4], m_page[4];
    logic [3:0]  m_mask, m_tc, m_req;
    logic [7:0]  m_cmd;
    bit          m_ptr;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int page_ch(input logic [7:0] a);
        case (a)
            8'h87: return 0;
            8'h83: return 1;
            8'h81: return 2;
            8'h82: return 3;
            default: return -1;
        endcase
    endfunction

    function automatic logic [7:0] m_read(input logic [7:0] a);
        logic [15:0] v;
        if (a < 8'h08) begin
            v = a[0] ? m_cc[a[2:1]] : m_ca[a[2:1]];
            return m_ptr ? v[15:8] : v[7:0];
        end
        if (a == 8'h08) return {m_req, m_tc};
        if (page_ch(a) >= 0) return m_page[page_ch(a)];
        return 8'h00;
    endfunction

    task automatic m_reset();
        for (int c = 0; c < 4; c++) begin
            m_ca[c] = 0; m_ba[c] = 0; m_cc[c] = 0; m_bc[c] = 0; m_mode[c] = 0; m_page[c] = 0;
        end
        m_mask = 4'hF; m_tc = 0; m_req = 0; m_cmd = 0; m_ptr = 0;
    endtask

    task automatic m_update(input bit w, input bit r, input logic [7:0] a,
                            input logic [7:0] d, input logic [3:0] s);
        logic [3:0] newtc;
        bit rd_e, hit_chan;
        newtc = 0;
        rd_e = r && !w;
        hit_chan = (a < 8'h08);
        for (int c = 0; c < 4; c++) begin
            if (s[c] && !m_mask[c] && !(w && hit_chan && a[2:1] == c)) begin
                m_ca[c] = m_ca[c] + 16'd1;
                if (m_cc[c] == 0) newtc[c] = 1'b1;
                m_cc[c] = m_cc[c] - 16'd1;
            end
        end
        if (w && hit_chan) begin
            if (a[0]) begin
                if (m_ptr) begin m_cc[a[2:1]][15:8] = d; m_bc[a[2:1]][15:8] = d; end
                else       begin m_cc[a[2:1]][7:0]  = d; m_bc[a[2:1]][7:0]  = d; end
            end else begin
                if (m_ptr) begin m_ca[a[2:1]][15:8] = d; m_ba[a[2:1]][15:8] = d; end
                else       begin m_ca[a[2:1]][7:0]  = d; m_ba[a[2:1]][7:0]  = d; end
            end
        end
        if ((w || rd_e) && hit_chan) m_ptr = !m_ptr;
        if (rd_e && a == 8'h08) m_tc = 0;
        m_tc = m_tc | newtc;
        if (w) begin
            case (a)
                8'h08: m_cmd = d;
                8'h09: m_req[d[1:0]] = d[2];
                8'h0A: m_mask[d[1:0]] = d[2];
                8'h0B: m_mode[d[1:0]] = d;
                8'h0C: m_ptr = 0;
                8'h0D: begin m_mask = 4'hF; m_cmd = 0; m_req = 0; m_tc = 0; m_ptr = 0; end
                8'h0E: m_mask = 4'h0;
                8'h0F: m_mask = 4'hF;
                default: if (page_ch(a) >= 0) m_page[page_ch(a)] = d;
            endcase
        end
    endtask

    task automatic compare_all();
        for (int c = 0; c < 4; c++) begin
            chk("R8 cycle ch_addr", ch_addr[c*24 +: 24], {m_page[c], m_ca[c]});
            chk("R8 cycle ch_count", ch_count[c*16 +: 16], m_cc[c]);
            chk("R2 cycle base_addr", ch_base_addr[c*16 +: 16], m_ba[c]);
            chk("R2 cycle base_count", ch_base_count[c*16 +: 16], m_bc[c]);
            chk("R6 cycle mode", ch_mode[c*8 +: 8], m_mode[c]);
        end
        chk("R4 cycle mask", ch_mask, m_mask);
        chk("R9 cycle tc", tc_flags, m_tc);
        chk("R11 cycle req", sw_req, m_req);
        chk("R11 cycle cmd", cmd_out, m_cmd);
    endtask

    task automatic tick(input bit w, input bit r, input logic [7:0] a,
                        input logic [7:0] d, input logic [3:0] s);
        io_wr = w; io_rd = r; io_addr = a; io_wdata = d; xfer_step = s;
        #1;
        last_rd = io_rdata;
        chk("R2 cycle rdata", io_rdata, m_read(a));
        @(posedge clk);
        m_update(w, r, a, d, s);
        @(negedge clk);
        io_wr = 0; io_rd = 0; io_addr = 0; io_wdata = 0; xfer_step = 0;
        #1;
        compare_all();
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d); tick(1, 0, a, d, 4'h0); endtask
    task automatic rd(input logic [7:0] a);                    tick(0, 1, a, 8'h00, 4'h0); endtask
    task automatic stp(input logic [3:0] s);                   tick(0, 0, 8'h00, 8'h00, s); endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 reset mask", ch_mask, 4'hF);
        chk("R1 reset tc", tc_flags, 4'h0);
        compare_all();
        rd(8'h00);
        chk("R1 reset addr read", last_rd, 8'h00);
        wr(8'h0C, 8'h00);

        // R2 program channel 0
        wr(8'h00, 8'h34); wr(8'h00, 8'h12);
        wr(8'h01, 8'h02); wr(8'h01, 8'h00);
        wr(8'h87, 8'h05);
        chk("R7 ch0 full address", ch_addr[23:0], 24'h051234);
        chk("R2 ch0 base address", ch_base_addr[15:0], 16'h1234);
        chk("R2 ch0 count", ch_count[15:0], 16'h0002);
        rd(8'h00);
        chk("R2 read low byte", last_rd, 8'h34);
        rd(8'h00);
        chk("R3 read high byte after toggle", last_rd, 8'h12);

        // R6 mode
        wr(8'h0B, 8'h4A);
        chk("R6 mode ch2", ch_mode[23:16], 8'h4A);

        // R5 / R4 masks
        wr(8'h0E, 8'h00);
        chk("R5 clear all masks", ch_mask, 4'h0);
        wr(8'h0A, 8'h05);
        chk("R4 mask ch1 only", ch_mask, 4'h2);
        wr(8'h0A, 8'h01);
        chk("R4 unmask ch1", ch_mask, 4'h0);

        // R8 / R9 stepping through terminal count
        stp(4'h1);
        chk("R8 step count", ch_count[15:0], 16'h0001);
        stp(4'h1); stp(4'h1);
        chk("R9 count wrap", ch_count[15:0], 16'hFFFF);
        chk("R8 address after steps", ch_addr[23:0], 24'h051237);
        chk("R9 tc flag set", tc_flags, 4'h1);
        rd(8'h08);
        chk("R9 status read", last_rd, 8'h01);
        chk("R9 status clears flags", tc_flags, 4'h0);

        // R8 masked step ignored
        wr(8'h0F, 8'h00);
        chk("R5 set all masks", ch_mask, 4'hF);
        stp(4'h1);
        chk("R8 masked step ignored addr", ch_addr[23:0], 24'h051237);
        chk("R8 masked step ignored count", ch_count[15:0], 16'hFFFF);

        // R8 address wrap keeps page
        wr(8'h06, 8'hFF); wr(8'h06, 8'hFF);
        wr(8'h82, 8'hAB);
        wr(8'h0A, 8'h03);
        stp(4'h8);
        chk("R8 wrap keeps page", ch_addr[95:72], 24'hAB0000);
        chk("R9 ch3 tc", tc_flags, 4'h8);

        // R11 request and command
        wr(8'h09, 8'h06);
        chk("R11 request ch2", sw_req, 4'h4);
        wr(8'h08, 8'h5A);
        chk("R11 command", cmd_out, 8'h5A);

        // R10 master clear with pointer set
        wr(8'h00, 8'h77);
        wr(8'h0D, 8'h00);
        chk("R10 masks set", ch_mask, 4'hF);
        chk("R10 cmd cleared", cmd_out, 8'h00);
        chk("R10 req cleared", sw_req, 4'h0);
        chk("R10 tc cleared", tc_flags, 4'h0);
        chk("R10 address kept", ch_addr[23:0], 24'h051277);
        wr(8'h00, 8'h88);
        chk("R10 pointer cleared", ch_addr[23:0], 24'h051288);

        // R3 pointer clear ignores data
        wr(8'h0C, 8'hFF);
        wr(8'h00, 8'h99);
        chk("R3 clear pointer any data", ch_addr[23:0], 24'h051299);

        // R8 write beats step
        wr(8'h0A, 8'h00);
        tick(1, 0, 8'h01, 8'h00, 4'h1);
        chk("R8 write suppresses step count", ch_count[15:0], 16'h00FF);
        chk("R8 write suppresses step addr", ch_addr[23:0], 24'h051299);

        // R12 / R10 / R7 reads
        rd(8'h0B);
        chk("R12 write-only port reads zero", last_rd, 8'h00);
        rd(8'h0D);
        chk("R10 temp reads zero", last_rd, 8'h00);
        rd(8'h50);
        chk("R12 unmapped port reads zero", last_rd, 8'h00);
        rd(8'h87);
        chk("R7 page ch0 read", last_rd, 8'h05);
        rd(8'h82);
        chk("R7 page ch3 read", last_rd, 8'hAB);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule